// File: doc/BRIEF.md
# Coarse-Fine Regulator Switch Controller

This block is the clocked controller of a digital low-dropout regulator whose power-switch array is split into two banks. A voltage-scaling host writes a 7-bit coarse code with a one-cycle load strobe. The code drives the coarse bank directly, and a bit value of 1 turns the matching coarse switch off. After each load, an 8-bit thermometer word for the fine bank restarts at mid-scale. The word then walks one step per clock, in the direction given by a clocked comparator that reports whether the regulated output is above its reference.

After a fixed settling window following each load, the controller arms a fast compensation path. While the path is armed, two window-comparator flags ask for a charge-up or a discharge of the compensation node. The comparators, the switch array and the compensation current source stay outside this block and reach it only as single-bit inputs.

The control state machine has three states:
- ST_IDLE: after reset; no code has been loaded and the fine word is held.
- ST_SETTLE: the fine word tracks the comparator and the settling counter runs.
- ST_ARMED: tracking continues and compensation is enabled.

Its transitions are:
- IDLE to SETTLE on a load.
- SETTLE to SETTLE on a load, which restarts the window.
- SETTLE to ARMED when the count completes without a load in the same cycle.
- ARMED to SETTLE on a load.

Top module: `cfldo_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, the controller returns to ST_IDLE. After that edge, coarse_ctl is 7'b1111111, fine_ctl is 8'b11110000 (upper half ones), and track_en, comp_en, chg_up and chg_dn are all 0.
- R2: A rising edge with code_load high copies code_in to coarse_ctl and sets fine_ctl to 8'b11110000. It also sets track_en to 1 from that edge on, and this takes priority over any comparator step.
- R3: While tracking, a comparator value of 1 causes the next rising edge to set the highest cleared bit of fine_ctl (for example 11110000 becomes 11111000).
- R4: While tracking, a comparator value of 0 causes the next rising edge to clear the lowest set bit of fine_ctl (for example 11110000 becomes 11100000).
- R5: fine_ctl saturates. A further up-step at 11111111, or a further down-step at 00000000, leaves it unchanged.
- R6: cmp_hi is sampled on the falling clock edge. A change of cmp_hi between that falling edge and the next rising edge has no effect on that rising edge's step.
- R7: Before the first load after reset, fine_ctl does not move, whatever the value of cmp_hi.
- R8: comp_en is 0 for the first six rising edges after a load edge and becomes 1 after the seventh, provided no further load arrives.
- R9: A load while tracking, including a load on the edge that would arm, clears comp_en after that edge and restarts the seven-edge window.
- R10: chg_up = comp_en & win_over & !win_under, and chg_dn = comp_en & win_under & !win_over. When both flags are high, or when comp_en is 0, neither request is issued.
- R11: Loading code 7'b1111111 (sleep) drives every coarse_ctl bit to 1, meaning all coarse switches are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the comparator is sampled on the falling edge and state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| code_in | input | 7 | Coarse code from the voltage-scaling host |
| code_load | input | 1 | One-cycle strobe that loads code_in |
| cmp_hi | input | 1 | Clocked comparator: 1 when the output is above the reference |
| win_over | input | 1 | Window flag: output above reference plus margin |
| win_under | input | 1 | Window flag: output below reference minus margin |
| coarse_ctl | output | 7 | Coarse switch controls; 1 means the switch is off |
| fine_ctl | output | 8 | Fine thermometer word, filled from the MSB |
| track_en | output | 1 | Fine tracking enabled since the last load |
| comp_en | output | 1 | Compensation path armed |
| chg_up | output | 1 | Request to charge the compensation node |
| chg_dn | output | 1 | Request to discharge the compensation node |

## Verification
A coarse load and the completion of the settling count can land on the same rising edge. The same edge can also carry a pending comparator step. The bench provokes this by loading a new code on exactly the seventh edge after a previous load. It judges the result by comp_en staying 0 after that edge, fine_ctl reading mid-scale rather than stepped, and comp_en rising only seven edges later. The two window flags asserted together while armed are a second such coincidence, and the bench checks that both requests stay low.

// File: rtl/cfldo_pkg.sv
package cfldo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_ARMED  = 2'd2
    } ctl_state_t;

    function automatic logic [7:0] therm_mid8();
        return 8'hF0;
    endfunction

endpackage

// File: rtl/cfldo_cmp_sampler.sv
module cfldo_cmp_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_in,
    output logic cmp_q
);

    // decision latched half a cycle before the rising edge uses it
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            cmp_q <= 1'b0;
        end else begin
            cmp_q <= cmp_in;
        end
    end

endmodule

// File: rtl/cfldo_fine_shifter.sv
module cfldo_fine_shifter #(
    parameter int FINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step_en,
    input  logic              step_up,
    output logic [FINE_W-1:0] fine_q
);

    localparam int HALF = FINE_W / 2;

    for (genvar i = 0; i < FINE_W; i++) begin : g_bit
        logic mid_val;
        logic up_val;
        logic dn_val;

        assign mid_val = (i >= HALF) ? 1'b1 : 1'b0;

        if (i == FINE_W - 1) begin : g_top
            assign up_val = 1'b1;
        end else begin : g_mid_up
            assign up_val = fine_q[i+1];
        end

        if (i == 0) begin : g_bot
            assign dn_val = 1'b0;
        end else begin : g_mid_dn
            assign dn_val = fine_q[i-1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fine_q[i] <= mid_val;
            end else if (restart) begin
                fine_q[i] <= mid_val;
            end else if (step_en) begin
                fine_q[i] <= step_up ? up_val : dn_val;
            end
        end
    end

endmodule

// File: rtl/cfldo_settle_timer.sv
module cfldo_settle_timer #(
    parameter int SETTLE_CYC = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic done
);

    localparam int TW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(SETTLE_CYC - 1);

    logic [TW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cfldo_window_arb.sv
module cfldo_window_arb (
    input  logic armed,
    input  logic over,
    input  logic under,
    output logic up_req,
    output logic dn_req
);

    always_comb begin
        up_req = 1'b0;
        dn_req = 1'b0;
        if (armed) begin
            unique case ({over, under})
                2'b10:   up_req = 1'b1;
                2'b01:   dn_req = 1'b1;
                default: begin
                    up_req = 1'b0;
                    dn_req = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/cfldo_ctrl.sv
module cfldo_ctrl #(
    parameter int CODE_W     = 7,
    parameter int FINE_W     = 8,
    parameter int SETTLE_CYC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              code_load,
    input  logic              cmp_hi,
    input  logic              win_over,
    input  logic              win_under,
    output logic [CODE_W-1:0] coarse_ctl,
    output logic [FINE_W-1:0] fine_ctl,
    output logic              track_en,
    output logic              comp_en,
    output logic              chg_up,
    output logic              chg_dn
);
    import cfldo_pkg::*;

    localparam logic [CODE_W-1:0] SLEEP_CODE = '1;

    ctl_state_t state_q;
    ctl_state_t state_d;
    logic       cmp_q;
    logic       settle_done;
    logic       tracking;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (code_load) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (code_load)        state_d = ST_SETTLE;
                else if (settle_done) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (code_load) state_d = ST_SETTLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        tracking = 1'b0;
        comp_en  = 1'b0;
        unique case (state_q)
            ST_IDLE:   begin tracking = 1'b0; comp_en = 1'b0; end
            ST_SETTLE: begin tracking = 1'b1; comp_en = 1'b0; end
            ST_ARMED:  begin tracking = 1'b1; comp_en = 1'b1; end
            default:   begin tracking = 1'b0; comp_en = 1'b0; end
        endcase
    end

    assign track_en = tracking;

    // coarse code register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_ctl <= SLEEP_CODE;
        end else if (code_load) begin
            coarse_ctl <= code_in;
        end
    end

    cfldo_cmp_sampler u_samp (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_in (cmp_hi),
        .cmp_q  (cmp_q)
    );

    cfldo_fine_shifter #(.FINE_W(FINE_W)) u_fine (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (code_load),
        .step_en (tracking),
        .step_up (cmp_q),
        .fine_q  (fine_ctl)
    );

    cfldo_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (code_load),
        .run     (state_q == ST_SETTLE),
        .done    (settle_done)
    );

    cfldo_window_arb u_arb (
        .armed  (comp_en),
        .over   (win_over),
        .under  (win_under),
        .up_req (chg_up),
        .dn_req (chg_dn)
    );

endmodule

// File: rtl/cfldo_ctrl_chk.sv
module cfldo_ctrl_chk #(
    parameter int CODE_W     = 7,
    parameter int FINE_W     = 8,
    parameter int SETTLE_CYC = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code_in,
    input logic              code_load,
    input logic              win_over,
    input logic              win_under,
    input logic              cmp_q,
    input logic [CODE_W-1:0] coarse_ctl,
    input logic [FINE_W-1:0] fine_ctl,
    input logic              track_en,
    input logic              comp_en,
    input logic              chg_up,
    input logic              chg_dn
);

    localparam int KW = $clog2(SETTLE_CYC + 1);
    localparam logic [FINE_W-1:0] MID = {{(FINE_W - FINE_W/2){1'b1}}, {(FINE_W/2){1'b0}}};

    logic [KW-1:0] since_load;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_load <= '0;
        end else if (code_load) begin
            since_load <= '0;
        end else if (since_load != KW'(SETTLE_CYC)) begin
            since_load <= since_load + 1'b1;
        end
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        code_load |=> (fine_ctl == MID) && (coarse_ctl == $past(code_in)) && track_en);

    p_therm_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fine_ctl ^ {fine_ctl[FINE_W-2:0], 1'b0}) <= 1);

    p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (track_en && !code_load && cmp_q && (fine_ctl != '1))
        |=> $countones(fine_ctl) == $countones($past(fine_ctl)) + 1);

    p_step_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (track_en && !code_load && !cmp_q && (fine_ctl != '0))
        |=> $countones(fine_ctl) + 1 == $countones($past(fine_ctl)));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!track_en && !code_load) |=> $stable(fine_ctl));

    p_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        comp_en |-> since_load == KW'(SETTLE_CYC));

    p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        code_load |=> !comp_en);

    p_no_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(chg_up && chg_dn));

    p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_up || chg_dn) |-> (comp_en && (win_over != win_under)));

endmodule

bind cfldo_ctrl cfldo_ctrl_chk #(
    .CODE_W     (CODE_W),
    .FINE_W     (FINE_W),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_in    (code_in),
    .code_load  (code_load),
    .win_over   (win_over),
    .win_under  (win_under),
    .cmp_q      (cmp_q),
    .coarse_ctl (coarse_ctl),
    .fine_ctl   (fine_ctl),
    .track_en   (track_en),
    .comp_en    (comp_en),
    .chg_up     (chg_up),
    .chg_dn     (chg_dn)
);

// File: tb/cfldo_ctrl_test.sv
`timescale 1ns/1ps
module cfldo_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] code_in = '0;
    logic       code_load = 1'b0;
    logic       cmp_hi = 1'b0;
    logic       win_over = 1'b0;
    logic       win_under = 1'b0;
    logic [6:0] coarse_ctl;
    logic [7:0] fine_ctl;
    logic       track_en;
    logic       comp_en;
    logic       chg_up;
    logic       chg_dn;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfldo_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_in    (code_in),
        .code_load  (code_load),
        .cmp_hi     (cmp_hi),
        .win_over   (win_over),
        .win_under  (win_under),
        .coarse_ctl (coarse_ctl),
        .fine_ctl   (fine_ctl),
        .track_en   (track_en),
        .comp_en    (comp_en),
        .chg_up     (chg_up),
        .chg_dn     (chg_dn)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [6:0] c);
        code_in = c;
        code_load = 1'b1;
        step();
        code_load = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cmp_hi = 1'b1;
        step();
        step();
        chk(coarse_ctl == 7'h7F, "R1 coarse", coarse_ctl, 7'h7F);
        chk(fine_ctl == 8'hF0, "R1 fine", fine_ctl, 8'hF0);
        chk({track_en, comp_en, chg_up, chg_dn} == 4'b0, "R1 enables", {track_en, comp_en, chg_up, chg_dn}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_idle_hold();
        cmp_hi = 1'b1;
        step(); step(); step();
        chk(fine_ctl == 8'hF0, "R7 idle up", fine_ctl, 8'hF0);
        cmp_hi = 1'b0;
        step(); step();
        chk(fine_ctl == 8'hF0, "R7 idle dn", fine_ctl, 8'hF0);
        chk(track_en == 1'b0, "R7 track_en", track_en, 0);
    endtask

    task automatic t_load_and_steps();
        cmp_hi = 1'b1;
        load(7'h05);
        chk(coarse_ctl == 7'h05, "R2 coarse", coarse_ctl, 7'h05);
        chk(fine_ctl == 8'hF0, "R2 fine mid", fine_ctl, 8'hF0);
        chk(track_en == 1'b1, "R2 track_en", track_en, 1);
        step();
        chk(fine_ctl == 8'hF8, "R3 up step", fine_ctl, 8'hF8);
        step();
        chk(fine_ctl == 8'hFC, "R3 up step2", fine_ctl, 8'hFC);
        cmp_hi = 1'b0;
        step();
        chk(fine_ctl == 8'hF8, "R4 down step", fine_ctl, 8'hF8);
        step(); step();
        chk(fine_ctl == 8'hE0, "R4 down x2", fine_ctl, 8'hE0);
    endtask

    task automatic t_saturate();
        cmp_hi = 1'b1;
        load(7'h22);
        for (int i = 0; i < 4; i++) step();
        chk(fine_ctl == 8'hFF, "R5 reach top", fine_ctl, 8'hFF);
        step(); step();
        chk(fine_ctl == 8'hFF, "R5 hold top", fine_ctl, 8'hFF);
        cmp_hi = 1'b0;
        for (int i = 0; i < 8; i++) step();
        chk(fine_ctl == 8'h00, "R5 reach bottom", fine_ctl, 8'h00);
        step(); step();
        chk(fine_ctl == 8'h00, "R5 hold bottom", fine_ctl, 8'h00);
    endtask

    task automatic t_falling_sample();
        cmp_hi = 1'b0;
        load(7'h10);
        cmp_hi = 1'b1;
        @(negedge clk);
        #1 cmp_hi = 1'b0;
        step();
        chk(fine_ctl == 8'hF8, "R6 late drop ignored", fine_ctl, 8'hF8);
        cmp_hi = 1'b0;
        @(negedge clk);
        #1 cmp_hi = 1'b1;
        step();
        chk(fine_ctl == 8'hF0, "R6 late rise ignored", fine_ctl, 8'hF0);
    endtask

    task automatic t_settle();
        bit early = 1'b0;
        cmp_hi = 1'b0;
        load(7'h30);
        for (int i = 1; i <= 6; i++) begin
            step();
            if (comp_en) early = 1'b1;
        end
        chk(!early, "R8 low for six edges", early, 0);
        step();
        chk(comp_en == 1'b1, "R8 armed at seventh", comp_en, 1);
    endtask

    task automatic t_reload();
        bit early = 1'b0;
        cmp_hi = 1'b1;
        load(7'h41);
        chk(comp_en == 1'b0, "R9 reload clears comp_en", comp_en, 0);
        chk(fine_ctl == 8'hF0, "R9 reload mid", fine_ctl, 8'hF0);
        for (int i = 1; i <= 6; i++) step();
        // seventh edge coincides with a new load
        load(7'h11);
        chk(comp_en == 1'b0, "R9 load beats arming", comp_en, 0);
        chk(fine_ctl == 8'hF0, "R9 load beats step", fine_ctl, 8'hF0);
        chk(coarse_ctl == 7'h11, "R2 coarse reload", coarse_ctl, 7'h11);
        for (int i = 1; i <= 6; i++) begin
            step();
            if (comp_en) early = 1'b1;
        end
        chk(!early, "R9 window restarted", early, 0);
        step();
        chk(comp_en == 1'b1, "R9 armed again", comp_en, 1);
    endtask

    task automatic t_window();
        // armed from previous task
        win_over = 1'b1; win_under = 1'b0; #1;
        chk({chg_up, chg_dn} == 2'b10, "R10 over", {chg_up, chg_dn}, 2'b10);
        win_over = 1'b0; win_under = 1'b1; #1;
        chk({chg_up, chg_dn} == 2'b01, "R10 under", {chg_up, chg_dn}, 2'b01);
        win_over = 1'b1; win_under = 1'b1; #1;
        chk({chg_up, chg_dn} == 2'b00, "R10 both", {chg_up, chg_dn}, 2'b00);
        win_over = 1'b0; win_under = 1'b0;
        load(7'h02);
        win_over = 1'b1; #1;
        chk({chg_up, chg_dn} == 2'b00, "R10 not armed over", {chg_up, chg_dn}, 2'b00);
        win_over = 1'b0; win_under = 1'b1; #1;
        chk({chg_up, chg_dn} == 2'b00, "R10 not armed under", {chg_up, chg_dn}, 2'b00);
        win_under = 1'b0;
    endtask

    task automatic t_sleep();
        load(7'h7F);
        chk(coarse_ctl == 7'h7F, "R11 sleep code", coarse_ctl, 7'h7F);
        chk(fine_ctl == 8'hF0, "R11 sleep fine mid", fine_ctl, 8'hF0);
        load(7'h00);
        chk(coarse_ctl == 7'h00, "R11 leave sleep", coarse_ctl, 7'h00);
    endtask

    task automatic t_reset_mid_run();
        cmp_hi = 1'b1;
        load(7'h0A);
        for (int i = 0; i < 8; i++) step();
        rst_n = 1'b0;
        step();
        chk({track_en, comp_en} == 2'b00, "R1 reset mid-run", {track_en, comp_en}, 0);
        chk(coarse_ctl == 7'h7F, "R1 reset coarse", coarse_ctl, 7'h7F);
        chk(fine_ctl == 8'hF0, "R1 reset fine", fine_ctl, 8'hF0);
        rst_n = 1'b1;
    endtask

    initial begin
        #1;
        t_reset();
        t_idle_hold();
        t_load_and_steps();
        t_saturate();
        t_falling_sample();
        t_settle();
        t_reload();
        t_window();
        t_sleep();
        t_reset_mid_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule